// File: doc/BRIEF.md
# Credit-Based Multi-Port Burst Scheduler

This block decides which of several logical ports owns a shared transmit path for the next burst. It keeps a credit count for every port. Flow-control reports from the far side refill these counts, and bytes actually sent use them up. A port becomes a candidate only when it has enough credit and enough queued data to fill a whole burst. Candidates are served in round-robin order.

While a port is being served, the scheduler works from a private snapshot of that port's credit, taken at the moment of selection. Refills that arrive during service go only to the per-port table, so the snapshot only ever falls. A static two-bit mode sets when service ends. The decision is made each time a full burst has gone out, and each time a beat carries end-of-packet. Depending on the mode, service then ends when credit or queued data has run short, when an end-of-packet has been sent, or always.

The surrounding transmitter sends the beats for the selected port and reports each beat here. The mode, the burst length and the two refill amounts are held constant outside reset.

Top module: `credit_tx_sched`

## Requirements
- R1: While reset is low, `sel_valid` is 0. After reset the search for the first grant begins at port 0.
- R2: A report with `stat_code` 2'b10 (starving) adds 16×`cfg_starve_amt` bytes to that port's credit. Code 2'b01 (hungry) adds 16×`cfg_hungry_amt`. Codes 2'b00 (satisfied) and 2'b11 add nothing.
- R3: A port is eligible only when its table credit and its `fifo_level` slice (port p at bits p×LEN_W and up) are both at least `cfg_burst_len`. If no port is eligible, `sel_valid` stays 0.
- R4: When `sel_valid` is 0 and some port is eligible, the first eligible port after the last served one, in wrapping order, is granted on the next clock. Every port change passes through at least one cycle with `sel_valid` 0. `sel_port` holds while `sel_valid` stays 1.
- R5: At grant, the port's table credit is copied into a current-credit register. Refills arriving during service do not raise the current credit.
- R6: A beat with `tx_valid` and `sel_valid` both 1 subtracts `tx_bytes` from the current credit and from the served port's table entry. Both saturate at 0. Beats while `sel_valid` is 0 change no credit.
- R7: Table credits saturate at 2^LEN_W−1 instead of wrapping.
- R8: A refill and a deduction for the same port in one cycle are both applied in that cycle.
- R9: A switch decision is made only on a beat that brings the bytes of the current burst to at least `cfg_burst_len`, or that carries `tx_eop`. The burst byte count restarts after every decision.
- R10: With `cfg_mode` 2'b00, a decision ends service only if the current credit after the beat, or the served port's `fifo_level`, is below `cfg_burst_len`.
- R11: With `cfg_mode` 2'b01, a decision ends service under the R10 condition, and also whenever the beat carries `tx_eop`.
- R12: With `cfg_mode` 2'b10 or 2'b11, every decision ends service, and `sel_valid` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_mode | input | 2 | Switching mode (static) |
| cfg_burst_len | input | LEN_W | Burst length in bytes (static) |
| cfg_starve_amt | input | AMT_W | Starving refill in 16-byte units (static) |
| cfg_hungry_amt | input | AMT_W | Hungry refill in 16-byte units (static) |
| stat_valid | input | 1 | Status report present |
| stat_port | input | PORT_W | Port the report refers to |
| stat_code | input | 2 | Report code |
| fifo_level | input | NUM_PORTS×LEN_W | Queued bytes per port |
| tx_valid | input | 1 | A beat was sent for the selected port |
| tx_bytes | input | BEAT_W | Bytes in that beat |
| tx_eop | input | 1 | That beat ends a packet |
| sel_valid | output | 1 | A port is currently selected |
| sel_port | output | PORT_W | Selected port |

## Verification
A wrong table credit shows up at the ports only through eligibility. A port is granted, or left idle, one clock after the wrong value is stored. The stimulus therefore drives credits to exactly the burst length, or just past it, so that an error of a single byte changes whether `sel_valid` rises. A wrong current credit or burst count shows on the beat that ends a burst: `sel_valid` drops one cycle too early or too late. A missing idle gap or a skipped round-robin position shows on the `sel_port` value of the next grant.

// File: rtl/cts_pkg.sv
// Shared definitions for the credit-based burst scheduler.
// Assumes the status code is two bits wide and refill units are 16 bytes.
package cts_pkg;
    typedef enum logic [1:0] {
        ST_SATISFIED = 2'b00,
        ST_HUNGRY    = 2'b01,
        ST_STARVING  = 2'b10,
        ST_SPARE     = 2'b11
    } stat_code_e;

    localparam int unsigned REFILL_SHIFT = 4;
endpackage

// File: rtl/cts_credit_table.sv
// Per-port credit table. Each entry gains the refill picked by a status
// report and loses the bytes of beats sent for that port, within one cycle.
// The result is clamped to [0, 2^LEN_W-1].
// Assumes AMT_W + 4 <= LEN_W and BEAT_W <= LEN_W.
module cts_credit_table #(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned LEN_W     = 12,
    parameter int unsigned AMT_W     = 7,
    parameter int unsigned BEAT_W    = 5,
    localparam int unsigned PORT_W   = $clog2(NUM_PORTS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            stat_valid,
    input  logic [PORT_W-1:0]               stat_port,
    input  logic [1:0]                      stat_code,
    input  logic [AMT_W-1:0]                cfg_starve_amt,
    input  logic [AMT_W-1:0]                cfg_hungry_amt,
    input  logic                            ded_valid,
    input  logic [PORT_W-1:0]               ded_port,
    input  logic [BEAT_W-1:0]               ded_bytes,
    output logic [NUM_PORTS-1:0][LEN_W-1:0] credit_q
);
    import cts_pkg::*;

    localparam int unsigned SUM_W = LEN_W + 1;
    localparam logic [SUM_W-1:0] CAP = SUM_W'({LEN_W{1'b1}});

    logic [SUM_W-1:0] refill_ext;
    logic [SUM_W-1:0] ded_ext;

    // Pick the refill amount, in bytes, that the current report carries.
    always_comb begin
        if (stat_code == ST_STARVING) begin
            refill_ext = SUM_W'({cfg_starve_amt, {REFILL_SHIFT{1'b0}}});
        end else if (stat_code == ST_HUNGRY) begin
            refill_ext = SUM_W'({cfg_hungry_amt, {REFILL_SHIFT{1'b0}}});
        end else begin
            refill_ext = '0;
        end
        ded_ext = SUM_W'(ded_bytes);
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_entry
        logic [LEN_W-1:0] cred_r;
        logic [LEN_W-1:0] cred_d;
        logic [SUM_W-1:0] gross;
        logic [SUM_W-1:0] net;
        logic             hit_refill;
        logic             hit_ded;

        // Add the refill and remove sent bytes, clamping at both ends.
        always_comb begin
            hit_refill = stat_valid && (stat_port == PORT_W'(p));
            hit_ded    = ded_valid && (ded_port == PORT_W'(p));
            gross      = {1'b0, cred_r} + (hit_refill ? refill_ext : '0);
            net        = gross;
            if (hit_ded) begin
                net = (gross > ded_ext) ? (gross - ded_ext) : '0;
            end
            cred_d = (net > CAP) ? CAP[LEN_W-1:0] : net[LEN_W-1:0];
        end

        // Hold the entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cred_r <= '0;
            end else begin
                cred_r <= cred_d;
            end
        end

        assign credit_q[p] = cred_r;
    end
endmodule

// File: rtl/cts_rr_pick.sv
// Round-robin picker. It finds the first set bit of the eligibility vector,
// starting one position after the last served port and wrapping around.
// Purely combinational. Assumes NUM_PORTS >= 2.
module cts_rr_pick #(
    parameter int unsigned NUM_PORTS = 4,
    localparam int unsigned PORT_W   = $clog2(NUM_PORTS)
) (
    input  logic [NUM_PORTS-1:0] elig,
    input  logic [PORT_W-1:0]    last_port,
    output logic                 grant_valid,
    output logic [PORT_W-1:0]    grant_port
);
    // Scan the ports in wrapping order after last_port; the first hit wins.
    always_comb begin
        grant_valid = 1'b0;
        grant_port  = '0;
        for (int off = 1; off <= int'(NUM_PORTS); off++) begin
            int idx;
            idx = int'(last_port) + off;
            if (idx >= int'(NUM_PORTS)) begin
                idx = idx - int'(NUM_PORTS);
            end
            if (!grant_valid && elig[idx]) begin
                grant_valid = 1'b1;
                grant_port  = PORT_W'(idx);
            end
        end
    end
endmodule

// File: rtl/cts_service_ctrl.sv
// Service controller. It holds the selected port, its stale current-credit
// snapshot and the byte count of the running burst. On a decision beat it
// applies the mode rule. Leaving costs one idle cycle before the next grant.
// Assumes BEAT_W <= LEN_W.
module cts_service_ctrl #(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned LEN_W     = 12,
    parameter int unsigned BEAT_W    = 5,
    localparam int unsigned PORT_W   = $clog2(NUM_PORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [LEN_W-1:0]  cfg_burst_len,
    input  logic              grant_valid,
    input  logic [PORT_W-1:0] grant_port,
    input  logic [LEN_W-1:0]  grant_credit,
    input  logic [LEN_W-1:0]  sel_fifo_level,
    input  logic              tx_valid,
    input  logic [BEAT_W-1:0] tx_bytes,
    input  logic              tx_eop,
    output logic              sel_valid,
    output logic [PORT_W-1:0] sel_port,
    output logic [PORT_W-1:0] last_port,
    output logic [LEN_W-1:0]  cur_cred
);
    localparam int unsigned CNT_W = LEN_W + 1;

    logic [LEN_W-1:0] burst_cnt;
    logic [LEN_W-1:0] bytes_ext;
    logic [LEN_W-1:0] cur_after;
    logic [CNT_W-1:0] burst_sum;
    logic             beat;
    logic             decide;
    logic             running_low;
    logic             leave;

    // Work out the effect of this cycle's beat and whether service ends.
    always_comb begin
        bytes_ext   = LEN_W'(tx_bytes);
        beat        = sel_valid && tx_valid;
        cur_after   = (cur_cred > bytes_ext) ? (cur_cred - bytes_ext) : '0;
        burst_sum   = {1'b0, burst_cnt} + {1'b0, bytes_ext};
        decide      = beat && ((burst_sum >= {1'b0, cfg_burst_len}) || tx_eop);
        running_low = (cur_after < cfg_burst_len) || (sel_fifo_level < cfg_burst_len);
        unique case (cfg_mode)
            2'b00:   leave = running_low;
            2'b01:   leave = running_low || tx_eop;
            default: leave = 1'b1;
        endcase
    end

    // Grant, serve and release ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_valid <= 1'b0;
            sel_port  <= '0;
            last_port <= PORT_W'(NUM_PORTS - 1);
            cur_cred  <= '0;
            burst_cnt <= '0;
        end else if (!sel_valid) begin
            if (grant_valid) begin
                sel_valid <= 1'b1;
                sel_port  <= grant_port;
                cur_cred  <= grant_credit;
                burst_cnt <= '0;
            end
        end else if (beat) begin
            cur_cred <= cur_after;
            if (decide) begin
                burst_cnt <= '0;
                if (leave) begin
                    sel_valid <= 1'b0;
                    last_port <= sel_port;
                end
            end else begin
                burst_cnt <= burst_sum[LEN_W-1:0];
            end
        end
    end
endmodule

// File: rtl/credit_tx_sched.sv
// Top of the credit-based multi-port burst scheduler. It ties the credit
// table, the eligibility test, the round-robin picker and the service
// controller together. Configuration inputs are static outside reset.
module credit_tx_sched #(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned LEN_W     = 12,
    parameter int unsigned AMT_W     = 7,
    parameter int unsigned BEAT_W    = 5,
    localparam int unsigned PORT_W   = $clog2(NUM_PORTS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   cfg_mode,
    input  logic [LEN_W-1:0]             cfg_burst_len,
    input  logic [AMT_W-1:0]             cfg_starve_amt,
    input  logic [AMT_W-1:0]             cfg_hungry_amt,
    input  logic                         stat_valid,
    input  logic [PORT_W-1:0]            stat_port,
    input  logic [1:0]                   stat_code,
    input  logic [NUM_PORTS*LEN_W-1:0]   fifo_level,
    input  logic                         tx_valid,
    input  logic [BEAT_W-1:0]            tx_bytes,
    input  logic                         tx_eop,
    output logic                         sel_valid,
    output logic [PORT_W-1:0]            sel_port
);
    logic [NUM_PORTS-1:0][LEN_W-1:0] fifo_arr;
    logic [NUM_PORTS-1:0][LEN_W-1:0] credit_q;
    logic [NUM_PORTS-1:0]            elig_vec;
    logic                            grant_valid;
    logic [PORT_W-1:0]               grant_port;
    logic [PORT_W-1:0]               last_port;
    logic [LEN_W-1:0]                cur_cred;
    logic                            ded_valid;

    assign fifo_arr  = fifo_level;
    assign ded_valid = sel_valid && tx_valid;

    cts_credit_table #(
        .NUM_PORTS(NUM_PORTS), .LEN_W(LEN_W), .AMT_W(AMT_W), .BEAT_W(BEAT_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .stat_valid(stat_valid), .stat_port(stat_port), .stat_code(stat_code),
        .cfg_starve_amt(cfg_starve_amt), .cfg_hungry_amt(cfg_hungry_amt),
        .ded_valid(ded_valid), .ded_port(sel_port), .ded_bytes(tx_bytes),
        .credit_q(credit_q)
    );

    // A port qualifies when both credit and queued data cover one burst.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_elig
        assign elig_vec[p] = (credit_q[p] >= cfg_burst_len) &&
                             (fifo_arr[p] >= cfg_burst_len);
    end

    cts_rr_pick #(.NUM_PORTS(NUM_PORTS)) u_pick (
        .elig(elig_vec), .last_port(last_port),
        .grant_valid(grant_valid), .grant_port(grant_port)
    );

    cts_service_ctrl #(
        .NUM_PORTS(NUM_PORTS), .LEN_W(LEN_W), .BEAT_W(BEAT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_mode(cfg_mode), .cfg_burst_len(cfg_burst_len),
        .grant_valid(grant_valid), .grant_port(grant_port),
        .grant_credit(credit_q[grant_port]),
        .sel_fifo_level(fifo_arr[sel_port]),
        .tx_valid(tx_valid), .tx_bytes(tx_bytes), .tx_eop(tx_eop),
        .sel_valid(sel_valid), .sel_port(sel_port),
        .last_port(last_port), .cur_cred(cur_cred)
    );
endmodule

// File: rtl/cts_sched_checker.sv
// Assertion checker for credit_tx_sched, attached with bind below.
// It watches the grant, the stale credit snapshot and the switch rules.
module cts_sched_checker #(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned LEN_W     = 12,
    localparam int unsigned PORT_W   = $clog2(NUM_PORTS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           cfg_mode,
    input logic                 tx_valid,
    input logic                 tx_eop,
    input logic                 sel_valid,
    input logic [PORT_W-1:0]    sel_port,
    input logic [LEN_W-1:0]     cur_cred,
    input logic [NUM_PORTS-1:0] elig_vec
);
    logic [NUM_PORTS-1:0] elig_q;

    // Keep last cycle's eligibility for the grant check.
    always_ff @(posedge clk) begin
        if (!rst_n) elig_q <= '0;
        else        elig_q <= elig_vec;
    end

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !sel_valid);

    a_r3_grant_was_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_valid) |-> elig_q[sel_port]);

    a_r4_port_held: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && $past(sel_valid)) |-> (sel_port == $past(sel_port)));

    a_r5_current_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && $past(sel_valid)) |-> (cur_cred <= $past(cur_cred)));

    a_r11_leave_on_eop: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b01 && sel_valid && tx_valid && tx_eop) |=> !sel_valid);

    a_r12_leave_on_eop_always: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode[1] && sel_valid && tx_valid && tx_eop) |=> !sel_valid);
endmodule

bind credit_tx_sched cts_sched_checker #(
    .NUM_PORTS(NUM_PORTS), .LEN_W(LEN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
    .tx_valid(tx_valid), .tx_eop(tx_eop),
    .sel_valid(sel_valid), .sel_port(sel_port),
    .cur_cred(cur_cred), .elig_vec(elig_vec)
);

// File: tb/credit_tx_sched_tb_top.sv
// Self-checking bench: a vector table for refill codes and eligibility,
// then directed tests for rotation, modes and credit corner cases.
module credit_tx_sched_tb_top;
    localparam int unsigned NP   = 4;
    localparam int unsigned LW   = 12;
    localparam int unsigned AW   = 7;
    localparam int unsigned BW   = 5;
    localparam int unsigned PW   = 2;

    typedef struct packed {
        logic [1:0]    code;
        logic [3:0]    reps;
        logic [LW-1:0] fifo;
        logic          exp_valid;
    } vec_t;

    // burst 64, starving = 64 bytes, hungry = 32 bytes, reports go to port 2
    localparam vec_t VECS [6] = '{
        '{2'b10, 4'd1, 12'd64,  1'b1},
        '{2'b01, 4'd1, 12'd64,  1'b0},
        '{2'b01, 4'd2, 12'd64,  1'b1},
        '{2'b00, 4'd3, 12'd200, 1'b0},
        '{2'b10, 4'd1, 12'd63,  1'b0},
        '{2'b11, 4'd2, 12'd200, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cfg_mode = 2'b10;
    logic [LW-1:0]     cfg_burst_len = 12'd64;
    logic [AW-1:0]     cfg_starve_amt = 7'd4;
    logic [AW-1:0]     cfg_hungry_amt = 7'd2;
    logic              stat_valid = 1'b0;
    logic [PW-1:0]     stat_port = '0;
    logic [1:0]        stat_code = 2'b00;
    logic [NP*LW-1:0]  fifo_level = '0;
    logic              tx_valid = 1'b0;
    logic [BW-1:0]     tx_bytes = '0;
    logic              tx_eop = 1'b0;
    logic              sel_valid;
    logic [PW-1:0]     sel_port;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    credit_tx_sched dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
        .cfg_burst_len(cfg_burst_len), .cfg_starve_amt(cfg_starve_amt),
        .cfg_hungry_amt(cfg_hungry_amt), .stat_valid(stat_valid),
        .stat_port(stat_port), .stat_code(stat_code), .fifo_level(fifo_level),
        .tx_valid(tx_valid), .tx_bytes(tx_bytes), .tx_eop(tx_eop),
        .sel_valid(sel_valid), .sel_port(sel_port)
    );

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_sel(string req, bit exp_v, int exp_p);
        chk(req, int'(sel_valid), int'(exp_v));
        if (exp_v && sel_valid) chk(req, int'(sel_port), exp_p);
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_fifo(int p, int lvl);
        fifo_level[p*LW +: LW] = LW'(lvl);
    endtask

    task automatic start(logic [1:0] mode, int burst, int starve, int hungry);
        rst_n = 1'b0;
        cfg_mode = mode;
        cfg_burst_len = LW'(burst);
        cfg_starve_amt = AW'(starve);
        cfg_hungry_amt = AW'(hungry);
        fifo_level = '0;
        stat_valid = 1'b0;
        tx_valid = 1'b0;
        tx_eop = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
    endtask

    // One cycle of stimulus: optional report and optional beat.
    task automatic step(bit sv, int sp, logic [1:0] sc, bit tv, int nb, bit eop);
        stat_valid = sv;
        stat_port  = PW'(sp);
        stat_code  = sc;
        tx_valid   = tv;
        tx_bytes   = BW'(nb);
        tx_eop     = eop;
        @(negedge clk);
        stat_valid = 1'b0;
        tx_valid   = 1'b0;
        tx_eop     = 1'b0;
    endtask

    task automatic report(int p, logic [1:0] c);
        step(1'b1, p, c, 1'b0, 0, 1'b0);
    endtask

    task automatic beat(int nb, bit eop);
        step(1'b0, 0, 2'b00, 1'b1, nb, eop);
    endtask

    initial begin
        // R1: reset state
        start(2'b10, 64, 4, 2);
        chk_sel("R1 reset idle", 1'b0, 0);

        // R2 / R3: vector table of refill codes against thresholds
        for (int i = 0; i < 6; i++) begin
            start(2'b10, 64, 4, 2);
            set_fifo(2, int'(VECS[i].fifo));
            for (int k = 0; k < int'(VECS[i].reps); k++) report(2, VECS[i].code);
            wait_cyc(2);
            chk_sel($sformatf("R2 R3 vector %0d", i), VECS[i].exp_valid, 2);
        end

        // R4 / R12: rotation in mode 10, one burst per port
        start(2'b10, 64, 4, 2);
        for (int p = 0; p < 4; p++) set_fifo(p, 200);
        for (int p = 0; p < 4; p++) begin
            report(p, 2'b10);
            report(p, 2'b10);
        end
        chk_sel("R1 first grant port 0", 1'b1, 0);
        for (int r = 1; r <= 4; r++) begin
            for (int b = 0; b < 4; b++) beat(16, 1'b0);
            chk_sel("R12 leave after burst", 1'b0, 0);
            wait_cyc(1);
            chk_sel("R4 round robin", 1'b1, r % 4);
        end

        // R5 / R10: stale current credit in mode 00
        start(2'b00, 64, 8, 2);
        set_fifo(1, 200);
        report(1, 2'b10);
        wait_cyc(1);
        chk_sel("R5 grant port 1", 1'b1, 1);
        beat(16, 1'b1);
        chk_sel("R10 eop alone keeps port", 1'b1, 1);
        report(1, 2'b10);
        for (int b = 0; b < 4; b++) beat(16, 1'b0);
        chk_sel("R5 stale credit forces leave", 1'b0, 0);
        wait_cyc(1);
        chk_sel("R5 table kept refill", 1'b1, 1);

        // R11 / R9: mode 01, eop and low data
        start(2'b01, 64, 8, 2);
        set_fifo(0, 200);
        set_fifo(3, 200);
        report(0, 2'b10);
        report(3, 2'b10);
        chk_sel("R11 port 0 first", 1'b1, 0);
        beat(16, 1'b1);
        chk_sel("R11 leave on eop", 1'b0, 0);
        wait_cyc(1);
        chk_sel("R4 skip ineligible", 1'b1, 3);
        set_fifo(3, 10);
        for (int b = 0; b < 3; b++) beat(16, 1'b0);
        chk_sel("R9 no decision mid burst", 1'b1, 3);
        beat(16, 1'b0);
        chk_sel("R11 leave on low data", 1'b0, 0);
        wait_cyc(1);
        chk_sel("R4 back to port 0", 1'b1, 0);

        // R12: mode 11 leaves on eop
        start(2'b11, 64, 8, 2);
        set_fifo(2, 200);
        report(2, 2'b10);
        wait_cyc(1);
        chk_sel("R12 grant port 2", 1'b1, 2);
        beat(16, 1'b1);
        chk_sel("R12 leave on eop", 1'b0, 0);
        wait_cyc(1);
        chk_sel("R12 regrant port 2", 1'b1, 2);

        // R7: table credit clamps at the maximum
        start(2'b10, 4095, 127, 2);
        set_fifo(0, 4095);
        report(0, 2'b10);
        report(0, 2'b10);
        wait_cyc(1);
        chk_sel("R7 below cap", 1'b0, 0);
        report(0, 2'b10);
        wait_cyc(1);
        chk_sel("R7 clamped to cap", 1'b1, 0);

        // R6: overdraw clamps at zero
        start(2'b00, 16, 4, 1);
        set_fifo(1, 200);
        report(1, 2'b01);
        wait_cyc(1);
        chk_sel("R6 grant port 1", 1'b1, 1);
        beat(31, 1'b0);
        chk_sel("R6 leave after overdraw", 1'b0, 0);
        wait_cyc(2);
        chk_sel("R6 credit clamped at zero", 1'b0, 0);
        report(1, 2'b01);
        wait_cyc(1);
        chk_sel("R6 refill from zero", 1'b1, 1);

        // R8: refill and deduction in one cycle
        start(2'b00, 64, 4, 2);
        set_fifo(0, 200);
        report(0, 2'b10);
        wait_cyc(1);
        for (int b = 0; b < 3; b++) beat(16, 1'b0);
        step(1'b1, 0, 2'b10, 1'b1, 16, 1'b0);
        chk_sel("R8 leave on spent credit", 1'b0, 0);
        wait_cyc(1);
        chk_sel("R8 refill applied", 1'b1, 0);
        beat(16, 1'b1);
        chk_sel("R8 deduction applied", 1'b0, 0);

        // R6: beats while idle are ignored
        start(2'b10, 64, 4, 2);
        report(0, 2'b10);
        for (int b = 0; b < 4; b++) beat(16, 1'b0);
        set_fifo(0, 200);
        wait_cyc(2);
        chk_sel("R6 idle beats ignored", 1'b1, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule